// File: doc/BRIEF.md
# PN Direct-Sequence Spreader

This block spreads a slow serial data stream over a fast chip stream. A five-stage shift register with linear feedback produces a pseudo-noise chip sequence 31 chips long. Each outgoing chip is the modulo-2 sum of that chip and the current data bit. The data bit is held for many chips in a row, so every data bit becomes a long burst of chips, either the code itself or its complement.

The block runs on a chip-rate clock that is qualified by a single enable. On each enabled edge it registers three outputs: the raw code chip, the spread chip, and a marker that shows the chip at the start of each code period. The marker lets downstream logic and a bench line up with the code. An active-low clear returns the code to its starting point at any time.

Top module: `pn_ds_spreader`

## Requirements
- R1: While `rst_n` is low, `pn_chip`, `spread_chip` and `seq_start` are 0. The first enabled edge after the clear is released presents code chip index 0.
- R2: Over 31 enabled edges from the clear, `pn_chip` takes the values 0000011001011011110101000100111, listed from chip index 0 (leftmost) to chip index 30.
- R3: The code is periodic with period 31. Chip index 31·m + k equals chip index k for every m.
- R4: When `data_in` is 0 at an enabled edge, the `spread_chip` registered at that edge equals the `pn_chip` registered at the same edge.
- R5: When `data_in` is 1 at an enabled edge, the `spread_chip` registered at that edge is the complement of `pn_chip`.
- R6: On a clock edge with `chip_en` low, all outputs and the code position stay unchanged, whatever the value of `data_in`.
- R7: `seq_start` is 1 exactly while the presented chip is code index 0, once per 31 enabled edges, and 0 for all other chips.
- R8: The register state is never all zeros. A clear in the middle of a period restarts the code at chip index 0.
- R9: The feedback implements x^5 + x^2 + 1, using the tap at stage 2 and the tap at stage 5 (the output stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Asynchronous active-low clear; reloads the seed |
| chip_en | input | 1 | Advances the code and registers the outputs when high |
| data_in | input | 1 | Data bit, held over many chips |
| pn_chip | output | 1 | Registered raw code chip |
| spread_chip | output | 1 | Registered data XOR code chip |
| seq_start | output | 1 | High while the presented chip is code index 0 |

## Verification
The hardest case to reach from the ports is a code position that has to survive enable gaps while the data input keeps changing. Any drift by a single chip only shows up many chips later, as a pattern mismatch or a misplaced period marker. The bench therefore interleaves idle cycles with data toggles inside a full period, and checks every chip against its own copy of the 31-chip pattern. A mid-period clear, followed by a check that the code restarts at chip index 0, covers the second hard case.

// File: rtl/pn_spread_pkg.sv
package pn_spread_pkg;

  // Next state of a right-shifting feedback register of width w: the stage at
  // position 0 is the output end, the new bit enters at position w-1, and the
  // feedback is the output stage XOR the stage tap_stage places from the input.
  function automatic logic [31:0] lfsr_advance(input logic [31:0] st,
                                               input int unsigned w,
                                               input int unsigned tap_stage);
    logic [31:0] nx;
    logic        fb;
    fb = st[0] ^ st[w - tap_stage];
    nx = st >> 1;
    nx[w-1] = fb;
    return nx;
  endfunction

  // Chip polarity as seen outside the register.
  function automatic logic chip_of(input logic out_stage, input logic invert);
    return out_stage ^ invert;
  endfunction

  // Modulo-2 combination of chip and data.
  function automatic logic spread_of(input logic chip, input logic data);
    return chip ^ data;
  endfunction

endpackage

// File: rtl/pn_lfsr_core.sv
module pn_lfsr_core
  import pn_spread_pkg::*;
#(
  parameter int unsigned STAGES      = 5,
  parameter int unsigned TAP_STAGE   = 2,
  parameter logic [STAGES-1:0] SEED  = '1,
  parameter bit          INVERT_CHIP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [STAGES-1:0] state,
  output logic              chip,
  output logic              at_origin
);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_nx;
  logic [31:0]       wide_nx;

  assign wide_nx = lfsr_advance(32'(state_q), STAGES, TAP_STAGE);

  for (genvar i = 0; i < STAGES; i++) begin : g_next
    assign state_nx[i] = wide_nx[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (advance) state_q <= state_nx;
  end

  assign state     = state_q;
  assign chip      = chip_of(state_q[0], INVERT_CHIP);
  assign at_origin = (state_q == SEED);

endmodule

// File: rtl/pn_chip_combiner.sv
module pn_chip_combiner
  import pn_spread_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  input  logic chip,
  input  logic origin,
  input  logic data,
  output logic pn_q,
  output logic spread_q,
  output logic start_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pn_q     <= 1'b0;
      spread_q <= 1'b0;
      start_q  <= 1'b0;
    end else if (advance) begin
      pn_q     <= chip;
      spread_q <= spread_of(chip, data);
      start_q  <= origin;
    end
  end

endmodule

// File: rtl/pn_ds_spreader.sv
module pn_ds_spreader #(
  parameter int unsigned STAGES      = 5,
  parameter int unsigned TAP_STAGE   = 2,
  parameter logic [STAGES-1:0] SEED  = '1,
  parameter bit          INVERT_CHIP = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic data_in,
  output logic pn_chip,
  output logic spread_chip,
  output logic seq_start
);

  // Named internal events for the checker.
  logic [STAGES-1:0] lfsr_state;
  logic              chip_raw;
  logic              period_origin;

  pn_lfsr_core #(
    .STAGES      (STAGES),
    .TAP_STAGE   (TAP_STAGE),
    .SEED        (SEED),
    .INVERT_CHIP (INVERT_CHIP)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .advance   (chip_en),
    .state     (lfsr_state),
    .chip      (chip_raw),
    .at_origin (period_origin)
  );

  pn_chip_combiner u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (chip_en),
    .chip     (chip_raw),
    .origin   (period_origin),
    .data     (data_in),
    .pn_q     (pn_chip),
    .spread_q (spread_chip),
    .start_q  (seq_start)
  );

endmodule

// File: rtl/pn_ds_spreader_chk.sv
module pn_ds_spreader_chk #(
  parameter int unsigned STAGES = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_en,
  input logic              data_in,
  input logic              pn_chip,
  input logic              spread_chip,
  input logic              seq_start,
  input logic [STAGES-1:0] lfsr_state
);

  localparam int unsigned SEQ_LEN = (1 << STAGES) - 1;
  localparam int unsigned CNT_W   = $clog2(SEQ_LEN);

  // Independent count of enabled edges modulo the period.
  logic [CNT_W-1:0] pos_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else if (chip_en) pos_q <= (pos_q == CNT_W'(SEQ_LEN - 1)) ? '0 : pos_q + 1'b1;
  end

  // R8: the register never holds the lock-up value
  p_state_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  // R6: idle edges leave everything unchanged
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> ($stable(pn_chip) && $stable(spread_chip) && $stable(seq_start)
                  && $stable(lfsr_state)));

  // R4 / R5: spread chip relates to the code chip through the sampled data bit
  p_spread_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chip_en |=> (spread_chip == (pn_chip ^ $past(data_in))));

  // R7: the marker appears on the first chip of each period
  p_start_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && pos_q == '0) |=> seq_start);

  // R7: and nowhere else
  p_start_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && pos_q != '0) |=> !seq_start);

endmodule

bind pn_ds_spreader pn_ds_spreader_chk #(.STAGES(STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .chip_en     (chip_en),
  .data_in     (data_in),
  .pn_chip     (pn_chip),
  .spread_chip (spread_chip),
  .seq_start   (seq_start),
  .lfsr_state  (lfsr_state)
);

// File: tb/test_pn_ds_spreader.sv
module test_pn_ds_spreader;

  localparam logic [30:0] PATTERN = 31'b0000011001011011110101000100111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0;
  logic data_in = 1'b0;
  logic pn_chip, spread_chip, seq_start;

  int tests_run = 0;
  int tests_failed = 0;
  int idx = 0;
  logic e_pn = 1'b0, e_sp = 1'b0, e_st = 1'b0;

  always #2.5 clk = ~clk;

  pn_ds_spreader i_pn_ds_spreader (
    .clk (clk), .rst_n (rst_n), .chip_en (chip_en), .data_in (data_in),
    .pn_chip (pn_chip), .spread_chip (spread_chip), .seq_start (seq_start)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %0b expected %0b (chip index %0d)", tag, act, exp, idx);
    end
  endtask

  // One clock: drive at the falling edge, sample just after the rising edge.
  task automatic step(input logic en, input logic d);
    @(negedge clk);
    chip_en = en;
    data_in = d;
    @(posedge clk);
    #1;
    if (en) begin
      e_pn = PATTERN[30 - idx];
      e_sp = e_pn ^ d;
      e_st = (idx == 0);
      idx = (idx + 1) % 31;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " pn"}, pn_chip, e_pn);
    chk({tag, " spread"}, spread_chip, e_sp);
    chk({tag, " start"}, seq_start, e_st);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    chip_en = 1'b1;
    data_in = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    idx = 0; e_pn = 0; e_sp = 0; e_st = 0;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    chip_en = 1'b0;
  endtask

  // R2, R3, R4, R7: two full periods with data 0
  task automatic t_pattern_two_periods();
    for (int k = 0; k < 62; k++) begin
      step(1'b1, 1'b0);
      chk("R2 R3 pattern", pn_chip, e_pn);
      chk("R4 spread equals code", spread_chip, pn_chip);
      chk("R7 start marker", seq_start, e_st);
    end
  endtask

  // R5: one period with data 1
  task automatic t_spread_one();
    for (int k = 0; k < 31; k++) begin
      step(1'b1, 1'b1);
      chk("R5 spread inverted", spread_chip, ~e_pn);
      check_all("R5 full");
    end
  endtask

  // R6: idle cycles with toggling data between enabled chips
  task automatic t_enable_gaps();
    for (int k = 0; k < 40; k++) begin
      step(1'b1, k[2]);
      check_all("R6 active");
      step(1'b0, ~k[2]);
      check_all("R6 idle hold");
      step(1'b0, k[2]);
      check_all("R6 idle hold");
    end
  endtask

  // R4, R5: data bit held over groups of chips
  task automatic t_mixed_data();
    for (int k = 0; k < 70; k++) begin
      step(1'b1, (k / 7) % 2 == 1);
      check_all("R4 R5 mixed data");
    end
  endtask

  // R8, R1: clear in mid-period restarts at chip index 0
  task automatic t_midrun_clear();
    for (int k = 0; k < 13; k++) step(1'b1, 1'b0);
    t_reset();
    step(1'b1, 1'b0);
    chk("R8 restart start", seq_start, 1'b1);
    chk("R1 first chip", pn_chip, PATTERN[30]);
    for (int k = 0; k < 40; k++) begin
      step(1'b1, 1'b1);
      check_all("R8 R9 after clear");
    end
  endtask

  initial begin
    t_reset();
    t_pattern_two_periods();
    t_spread_one();
    t_enable_gaps();
    t_mixed_data();
    t_midrun_clear();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule